// File: doc/BRIEF.md
# PLL configuration apply sequencer

This block takes a PLL setting that has already been worked out (input divider N, feedback multiplier M, up to four post-divider ratios and the comparison frequency Fint in hertz) and programs it into the PLL's control register block. It acts as the master on a simple request/acknowledge register bus. It writes the configuration words with the post-dividers held in bypass and triggers the apply bit. It then waits for the loop to lock. After lock it enables the post-divider outputs that are in use and waits for their acknowledges. The analog loop is outside the block. The block sees the loop only through the status and trigger registers it reads back.

Two waiting styles are offered. In the normal style the sequencer polls until the apply bit falls and then until the lock bit rises. In the retry style it fires the apply bit, lets a fixed settle time pass, and tests a masked status word together with the apply bit. It repeats this up to a bounded number of attempts. Each poll wait is limited by a counter, so a dead loop ends the run with an error instead of hanging it.

Top module: `pll_apply_seq`

## Requirements
- R1: After reset `busy`, `done`, `error` and `bus_req` are low, and `bus_req` stays low whenever `busy` is low.
- R2: A run writes offset 0x0C, then 0x14, then 0x10, then 0x08. The word at 0x0C carries N−1 in bits 8:1, M in bits 20:9, divider 0 in bits 25:21 and divider 1 in bits 30:26. Each divider field holds its ratio minus one, or 0 for a ratio of 0, which means the divider is unused.
- R3: The word at 0x14 carries divider 2 in bits 4:0 and divider 3 in bits 9:5, encoded as in R2.
- R4: The first write to 0x10 has bits 13 and 20 set and bits 14, 16, 18, 23 and 25 clear. Its bits 4:1 hold the frequency code.
- R5: The frequency code is 3 for Fint below 1 000 000 and 4 below 1 250 000. It is 5 below 1 500 000, 6 below 1 750 000, and 7 otherwise.
- R6: The write to 0x08 carries the value 1. In normal style the block then reads 0x08 until bit 0 is 0, and then reads 0x04 until bit 1 is 1.
- R7: After lock the second write to 0x10 keeps bits 4:1 and bit 13, sets bit 14 and clears bit 20. It sets bits 16, 18, 23 and 25 for dividers 0, 1, 2 and 3 when each is in use.
- R8: The block then reads 0x04 until bits 7, 8, 10 and 11 are set for the used dividers 0, 1, 2 and 3. It then pulses `done` for one cycle with `error` low. With no dividers in use, the first read completes the run.
- R9: Any poll wait fails after WAIT_POLLS unsatisfied reads. On failure `done` and `error` pulse together and no further bus transfer follows. A wait that is satisfied on its WAIT_POLLS-th read succeeds.
- R10: In retry style, after each write to 0x08 the block waits at least SETTLE_CYC cycles. It then reads 0x04 and then 0x08, and proceeds only when (status & 0x6F) == 0x03 and bit 0 of 0x08 is 0.
- R11: In retry style the block gives up with an error after MAX_TRIES writes to 0x08, which is 20 by default.
- R12: `start` is taken only when idle. Inputs are captured at that moment, and a `start` or input change during a run has no effect on it.
- R13: Once raised, `bus_req` with `bus_we`, `bus_addr` and `bus_wdata` stays unchanged until the cycle `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| retry_mode | input | 1 | 1 selects the settle-and-retry lock style |
| div_n | input | N_W | Input divider N (nonzero) |
| div_m | input | M_W | Feedback multiplier M |
| post_div0 | input | PD_W | Post-divider 0 ratio, 0 = unused |
| post_div1 | input | PD_W | Post-divider 1 ratio, 0 = unused |
| post_div2 | input | PD_W | Post-divider 2 ratio, 0 = unused |
| post_div3 | input | PD_W | Post-divider 3 ratio, 0 = unused |
| fint_hz | input | FINT_W | Comparison frequency in Hz |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Valid with `done`: run failed |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer complete (one cycle) |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
Within one poll, the read that satisfies a wait can also be the read that uses up its budget. The two outcomes then fall in the same response cycle, and success has to win. The bench models the lock bit to appear on exactly the WAIT_POLLS-th status read and expects a clean finish. It then delays the bit by one more read and expects `done` with `error` and no further transfers. In the same way, the retry style's masked lock test meets the attempt limit on the last try. A status word with an excluded bit set must pass, and one with high jitter flagged must run all 20 attempts and fail.

// File: rtl/pll_apply_pkg.sv
package pll_apply_pkg;

  localparam int WORD = 32;
  localparam int NDIV = 4;

  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_GO   = 8'h08;
  localparam logic [7:0] OFS_CFG1 = 8'h0C;
  localparam logic [7:0] OFS_CFG2 = 8'h10;
  localparam logic [7:0] OFS_CFG3 = 8'h14;

  localparam int BIT_REFEN = 13;
  localparam int BIT_PHYEN = 14;
  localparam int BIT_BYP   = 20;

  typedef enum logic [3:0] {
    S_IDLE, S_W_C1, S_W_C3, S_W_C2A, S_W_GO,
    S_POLL_GO, S_POLL_LK, S_SETTLE, S_R_ST, S_R_GO,
    S_W_C2B, S_POLL_ACK
  } seq_state_t;

  // Frequency band code from the comparison frequency.
  function automatic logic [3:0] fsel_code(input logic [31:0] f);
    if (f < 32'd1000000)      return 4'd3;
    else if (f < 32'd1250000) return 4'd4;
    else if (f < 32'd1500000) return 4'd5;
    else if (f < 32'd1750000) return 4'd6;
    else                      return 4'd7;
  endfunction

  // Output enable bits in the second control word, one per used divider.
  function automatic logic [WORD-1:0] div_en_bits(input logic [NDIV-1:0] used);
    logic [WORD-1:0] r;
    r = '0;
    r[16] = used[0];
    r[18] = used[1];
    r[23] = used[2];
    r[25] = used[3];
    return r;
  endfunction

  // Status acknowledge bits expected for the used dividers.
  function automatic logic [WORD-1:0] div_ack_bits(input logic [NDIV-1:0] used);
    logic [WORD-1:0] r;
    r = '0;
    r[7]  = used[0];
    r[8]  = used[1];
    r[10] = used[2];
    r[11] = used[3];
    return r;
  endfunction

  // Masked lock qualification: reset-done and lock set; recal, lossref,
  // high-jitter and bypass clear.
  function automatic logic lock_good(input logic [WORD-1:0] s);
    return (s & 32'h0000_006F) == 32'h0000_0003;
  endfunction

endpackage

// File: rtl/pll_word_build.sv
module pll_word_build
  import pll_apply_pkg::*;
#(
  parameter int N_W    = 8,
  parameter int M_W    = 12,
  parameter int PD_W   = 5,
  parameter int FINT_W = 32
) (
  input  logic [N_W-1:0]             n,
  input  logic [M_W-1:0]             m,
  input  logic [NDIV-1:0][PD_W-1:0]  pd,
  input  logic [FINT_W-1:0]          fint,
  output logic [WORD-1:0]            cfg1,
  output logic [WORD-1:0]            cfg3,
  output logic [WORD-1:0]            cfg2_pre,
  output logic [WORD-1:0]            cfg2_post,
  output logic [WORD-1:0]            ack_mask
);

  localparam int C1_N_LSB  = 1;
  localparam int C1_M_LSB  = C1_N_LSB + N_W;
  localparam int C1_D0_LSB = C1_M_LSB + M_W;
  localparam int C1_D1_LSB = C1_D0_LSB + PD_W;
  localparam int C3_D2_LSB = 0;
  localparam int C3_D3_LSB = PD_W;

  logic [NDIV-1:0]           used;
  logic [NDIV-1:0][PD_W-1:0] dw;
  logic [3:0]                fs;

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    assign used[i] = |pd[i];
    assign dw[i]   = used[i] ? pd[i] - PD_W'(1) : '0;
  end

  assign fs = fsel_code(32'(fint));

  always_comb begin
    cfg1 = '0;
    cfg1[C1_N_LSB  +: N_W]  = n - N_W'(1);
    cfg1[C1_M_LSB  +: M_W]  = m;
    cfg1[C1_D0_LSB +: PD_W] = dw[0];
    cfg1[C1_D1_LSB +: PD_W] = dw[1];

    cfg3 = '0;
    cfg3[C3_D2_LSB +: PD_W] = dw[2];
    cfg3[C3_D3_LSB +: PD_W] = dw[3];

    cfg2_pre = '0;
    cfg2_pre[4:1]       = fs;
    cfg2_pre[BIT_REFEN] = 1'b1;
    cfg2_pre[BIT_BYP]   = 1'b1;

    cfg2_post = div_en_bits(used);
    cfg2_post[4:1]       = fs;
    cfg2_post[BIT_REFEN] = 1'b1;
    cfg2_post[BIT_PHYEN] = 1'b1;

    ack_mask = div_ack_bits(used);
  end

endmodule

// File: rtl/pll_step_ctr.sv
module pll_step_ctr #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + CW'(1);
  end

  assign at_last = (cnt == CW'(LIMIT - 1));

  AST_CTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1)); // R9

endmodule

// File: rtl/pll_apply_seq.sv
module pll_apply_seq
  import pll_apply_pkg::*;
#(
  parameter int N_W        = 8,
  parameter int M_W        = 12,
  parameter int PD_W       = 5,
  parameter int FINT_W     = 32,
  parameter int AW         = 8,
  parameter int WAIT_POLLS = 100,
  parameter int SETTLE_CYC = 1000,
  parameter int MAX_TRIES  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              retry_mode,
  input  logic [N_W-1:0]    div_n,
  input  logic [M_W-1:0]    div_m,
  input  logic [PD_W-1:0]   post_div0,
  input  logic [PD_W-1:0]   post_div1,
  input  logic [PD_W-1:0]   post_div2,
  input  logic [PD_W-1:0]   post_div3,
  input  logic [FINT_W-1:0] fint_hz,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [WORD-1:0]   bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD-1:0]   bus_rdata
);

  seq_state_t st_q, st_d;

  logic [N_W-1:0]            n_q;
  logic [M_W-1:0]            m_q;
  logic [NDIV-1:0][PD_W-1:0] pd_q;
  logic [FINT_W-1:0]         fint_q;
  logic                      retry_q;
  logic                      lock_seen_q;
  logic                      req_q, we_q;
  logic [AW-1:0]             addr_q;
  logic [WORD-1:0]           wdata_q;
  logic                      done_q, err_q;

  logic [WORD-1:0] cfg1, cfg3, cfg2_pre, cfg2_post, ack_mask;

  pll_word_build #(.N_W(N_W), .M_W(M_W), .PD_W(PD_W), .FINT_W(FINT_W)) u_words (
    .n(n_q), .m(m_q), .pd(pd_q), .fint(fint_q),
    .cfg1(cfg1), .cfg3(cfg3), .cfg2_pre(cfg2_pre), .cfg2_post(cfg2_post),
    .ack_mask(ack_mask)
  );

  // Named events
  logic ev_start, ev_rsp, is_poll, poll_hit, ev_poll_miss, ev_timeout;
  logic ev_retry_ok, ev_retry_miss, ev_giveup, ev_fail, ev_ok;
  logic poll_last, settle_last, tries_last;

  assign ev_start = start && (st_q == S_IDLE);
  assign ev_rsp   = req_q && bus_ack;

  // Transfer each state wants on the bus
  logic            bus_st, tgt_we;
  logic [AW-1:0]   tgt_addr;
  logic [WORD-1:0] tgt_wdata;

  always_comb begin
    bus_st    = 1'b1;
    tgt_we    = 1'b0;
    tgt_addr  = AW'(OFS_STAT);
    tgt_wdata = '0;
    unique case (st_q)
      S_W_C1:   begin tgt_we = 1'b1; tgt_addr = AW'(OFS_CFG1); tgt_wdata = cfg1;      end
      S_W_C3:   begin tgt_we = 1'b1; tgt_addr = AW'(OFS_CFG3); tgt_wdata = cfg3;      end
      S_W_C2A:  begin tgt_we = 1'b1; tgt_addr = AW'(OFS_CFG2); tgt_wdata = cfg2_pre;  end
      S_W_C2B:  begin tgt_we = 1'b1; tgt_addr = AW'(OFS_CFG2); tgt_wdata = cfg2_post; end
      S_W_GO:   begin tgt_we = 1'b1; tgt_addr = AW'(OFS_GO);   tgt_wdata = 32'h1;     end
      S_POLL_GO, S_R_GO: tgt_addr = AW'(OFS_GO);
      S_POLL_LK, S_R_ST, S_POLL_ACK: tgt_addr = AW'(OFS_STAT);
      default: bus_st = 1'b0;
    endcase
  end

  // Poll qualification
  always_comb begin
    is_poll  = 1'b1;
    poll_hit = 1'b0;
    case (st_q)
      S_POLL_GO:  poll_hit = !bus_rdata[0];
      S_POLL_LK:  poll_hit = bus_rdata[1];
      S_POLL_ACK: poll_hit = (bus_rdata & ack_mask) == ack_mask;
      default:    is_poll  = 1'b0;
    endcase
  end

  assign ev_poll_miss  = ev_rsp && is_poll && !poll_hit;
  assign ev_timeout    = ev_poll_miss && poll_last;
  assign ev_retry_ok   = ev_rsp && (st_q == S_R_GO) && lock_seen_q && !bus_rdata[0];
  assign ev_retry_miss = ev_rsp && (st_q == S_R_GO) && !ev_retry_ok;
  assign ev_giveup     = ev_retry_miss && tries_last;
  assign ev_fail       = ev_timeout || ev_giveup;
  assign ev_ok         = ev_rsp && (st_q == S_POLL_ACK) && poll_hit;

  // Next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:     if (ev_start) st_d = S_W_C1;
      S_W_C1:     if (ev_rsp) st_d = S_W_C3;
      S_W_C3:     if (ev_rsp) st_d = S_W_C2A;
      S_W_C2A:    if (ev_rsp) st_d = S_W_GO;
      S_W_GO:     if (ev_rsp) st_d = retry_q ? S_SETTLE : S_POLL_GO;
      S_POLL_GO:  if (ev_rsp && poll_hit) st_d = S_POLL_LK;
      S_POLL_LK:  if (ev_rsp && poll_hit) st_d = S_W_C2B;
      S_SETTLE:   if (settle_last) st_d = S_R_ST;
      S_R_ST:     if (ev_rsp) st_d = S_R_GO;
      S_R_GO:     if (ev_rsp) st_d = ev_retry_ok ? S_W_C2B : S_W_GO;
      S_W_C2B:    if (ev_rsp) st_d = S_POLL_ACK;
      S_POLL_ACK: if (ev_ok) st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
    if (ev_fail) st_d = S_IDLE;
  end

  // Wait counters: poll budget, settle time, lock attempts
  pll_step_ctr #(.LIMIT(WAIT_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(st_d != st_q),
    .inc(ev_poll_miss && !poll_last), .at_last(poll_last)
  );

  pll_step_ctr #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(st_d != st_q),
    .inc((st_q == S_SETTLE) && !settle_last), .at_last(settle_last)
  );

  pll_step_ctr #(.LIMIT(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(ev_start),
    .inc(ev_retry_miss && !tries_last), .at_last(tries_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      n_q         <= '0;
      m_q         <= '0;
      pd_q        <= '0;
      fint_q      <= '0;
      retry_q     <= 1'b0;
      lock_seen_q <= 1'b0;
      req_q       <= 1'b0;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_start) begin
        n_q     <= div_n;
        m_q     <= div_m;
        pd_q    <= {post_div3, post_div2, post_div1, post_div0};
        fint_q  <= fint_hz;
        retry_q <= retry_mode;
      end
      if (ev_rsp && (st_q == S_R_ST)) lock_seen_q <= lock_good(bus_rdata);
      if (ev_rsp) begin
        req_q <= 1'b0;
      end else if (bus_st && !req_q) begin
        req_q   <= 1'b1;
        we_q    <= tgt_we;
        addr_q  <= tgt_addr;
        wdata_q <= tgt_wdata;
      end
      done_q <= ev_ok || ev_fail;
      err_q  <= ev_fail;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign bus_req   = req_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req); // R1
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done); // R9
  AST_GO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && (bus_addr == AW'(OFS_GO)) |-> bus_wdata == 32'h1); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(n_q) && $stable(pd_q) && $stable(retry_q)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_SETTLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SETTLE) |-> !bus_req); // R10

endmodule

// File: tb/test_pll_apply_seq.sv
module test_pll_apply_seq;

  localparam int WP = 8;
  localparam int SC = 16;
  localparam int MT = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        retry_mode = 1'b0;
  logic [7:0]  div_n = 8'd1;
  logic [11:0] div_m = 12'd0;
  logic [4:0]  post_div0 = '0, post_div1 = '0, post_div2 = '0, post_div3 = '0;
  logic [31:0] fint_hz = '0;
  logic        busy, done, error, bus_req, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  pll_apply_seq #(.WAIT_POLLS(WP), .SETTLE_CYC(SC), .MAX_TRIES(MT)) i_pll_apply_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .retry_mode(retry_mode),
    .div_n(div_n), .div_m(div_m), .post_div0(post_div0), .post_div1(post_div1),
    .post_div2(post_div2), .post_div3(post_div3), .fint_hz(fint_hz),
    .busy(busy), .done(done), .error(error), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // Register-block model knobs and records
  int go_busy_reads, go_left, lock_after, lock_from_try;
  int go_writes, st_reads, c2_writes, txn_cnt, cyc, go_cyc, min_gap, wcount, done_cnt;
  logic        go_reg, ack_ok;
  logic [31:0] lock_bits, c1, c3, c2a, c2b;
  logic [7:0]  wlog [0:15];
  logic        got_done, got_err;
  int          txn_at_done;

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        txn_cnt++;
        if (bus_we) begin
          if (wcount < 16) wlog[wcount] = bus_addr;
          wcount++;
          case (bus_addr)
            8'h0C: c1 = bus_wdata;
            8'h14: c3 = bus_wdata;
            8'h10: begin if (c2_writes == 0) c2a = bus_wdata; else c2b = bus_wdata; c2_writes++; end
            8'h08: begin go_writes++; go_reg = 1'b1; go_left = go_busy_reads; st_reads = 0; go_cyc = cyc; end
            default: ;
          endcase
        end else if (bus_addr == 8'h08) begin
          if (go_reg && go_left > 0) begin bus_rdata <= 32'h1; go_left--; end
          else begin go_reg = 1'b0; bus_rdata <= 32'h0; end
        end else begin
          logic [31:0] v;
          v = 32'h1;
          if (st_reads >= lock_after && go_writes >= lock_from_try) v = lock_bits;
          if (ack_ok && c2_writes > 1)
            v = v | ({20'd0, c2b[25], c2b[23], 1'b0, c2b[18], c2b[16], 7'd0});
          if (st_reads == 0 && (cyc - go_cyc) < min_gap) min_gap = cyc - go_cyc;
          st_reads++;
          bus_rdata <= v;
        end
      end else begin
        bus_ack <= 1'b0;
      end
    end
  end

  initial begin
    done_cnt = 0;
    forever begin @(negedge clk); if (done) done_cnt++; end
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dwv(input int v);
    return (v == 0) ? 32'd0 : 32'(v - 1);
  endfunction

  function automatic logic [31:0] exp_fs(input int f);
    int q;
    q = f / 250000;
    if (q < 4) return 32'd3;
    if (q > 6) return 32'd7;
    return 32'(q);
  endfunction

  function automatic logic [31:0] exp_c1(input int n, m, p0, p1);
    return (32'(n - 1) << 1) | (32'(m) << 9) | (dwv(p0) << 21) | (dwv(p1) << 26);
  endfunction

  function automatic logic [31:0] exp_c2b(input int f, p0, p1, p2, p3);
    logic [31:0] r;
    r = (exp_fs(f) << 1) | 32'h0000_6000;
    if (p0 != 0) r = r | 32'h0001_0000;
    if (p1 != 0) r = r | 32'h0004_0000;
    if (p2 != 0) r = r | 32'h0080_0000;
    if (p3 != 0) r = r | 32'h0200_0000;
    return r;
  endfunction

  task automatic prep();
    go_busy_reads = 2; lock_after = 1; lock_from_try = 0; lock_bits = 32'h3; ack_ok = 1'b1;
    go_writes = 0; st_reads = 0; c2_writes = 0; txn_cnt = 0; wcount = 0; min_gap = 1000000;
    go_reg = 1'b0; go_left = 0; go_cyc = 0; c1 = '0; c3 = '0; c2a = '0; c2b = '0;
  endtask

  task automatic wait_done();
    got_done = 1'b0; got_err = 1'b0;
    for (int i = 0; i < 20000 && !got_done; i++) begin
      @(negedge clk);
      if (done) begin got_done = 1'b1; got_err = error; txn_at_done = txn_cnt; end
    end
    chk("R8 done pulse seen", 32'(got_done), 32'd1);
  endtask

  task automatic run_seq(input int n, m, p0, p1, p2, p3, f, input logic rt);
    @(negedge clk);
    div_n = 8'(n); div_m = 12'(m);
    post_div0 = 5'(p0); post_div1 = 5'(p1); post_div2 = 5'(p2); post_div3 = 5'(p3);
    fint_hz = 32'(f); retry_mode = rt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  task automatic quiet_after(input string tag);
    repeat (12) @(negedge clk);
    chk(tag, 32'(txn_cnt), 32'(txn_at_done));
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 error after reset", 32'(error), 32'd0);
    chk("R1 bus_req after reset", 32'(bus_req), 32'd0);
  endtask

  task automatic t_all_div();
    prep();
    run_seq(4, 300, 5, 6, 7, 8, 900000, 1'b0);
    chk("R2 write order 0", 32'(wlog[0]), 32'h0C);
    chk("R2 write order 1", 32'(wlog[1]), 32'h14);
    chk("R2 write order 2", 32'(wlog[2]), 32'h10);
    chk("R2 write order 3", 32'(wlog[3]), 32'h08);
    chk("R2 config1 word", c1, exp_c1(4, 300, 5, 6));
    chk("R3 config3 word", c3, dwv(7) | (dwv(8) << 5));
    chk("R4 config2 pre-apply", c2a, (exp_fs(900000) << 1) | 32'h0010_2000);
    chk("R5 code below 1.0 MHz", 32'(c2a[4:1]), 32'd3);
    chk("R6 single apply write", 32'(go_writes), 32'd1);
    chk("R7 config2 post-lock", c2b, exp_c2b(900000, 5, 6, 7, 8));
    chk("R8 no error", 32'(got_err), 32'd0);
    chk("R1 idle after done", 32'(busy), 32'd0);
  endtask

  task automatic t_partial();
    prep();
    run_seq(1, 4095, 3, 0, 1, 0, 1300000, 1'b0);
    chk("R2 config1 unused divider", c1, exp_c1(1, 4095, 3, 0));
    chk("R3 config3 ratio one", c3, 32'd0);
    chk("R7 enables only used", c2b, exp_c2b(1300000, 3, 0, 1, 0));
    chk("R8 partial no error", 32'(got_err), 32'd0);
  endtask

  task automatic t_fsel_edges();
    int fl [5];
    fl = '{1000000, 1249999, 1499999, 1500000, 1750000};
    for (int k = 0; k < 5; k++) begin
      prep();
      run_seq(2, 50, 2, 0, 0, 0, fl[k], 1'b0);
      chk("R5 band code edge", 32'(c2a[4:1]), exp_fs(fl[k]));
    end
    prep();
    run_seq(2, 50, 2, 0, 0, 0, 1749999, 1'b0);
    chk("R5 band code 6", 32'(c2a[4:1]), 32'd6);
  endtask

  task automatic t_go_stuck();
    prep();
    go_busy_reads = 1000;
    run_seq(3, 100, 2, 2, 0, 0, 1100000, 1'b0);
    chk("R6 apply bit stuck errors", 32'(got_err), 32'd1);
    chk("R6 no post-lock write", 32'(c2_writes), 32'd1);
    quiet_after("R9 quiet after failure");
  endtask

  task automatic t_lock_edge();
    prep();
    lock_after = WP - 1;
    run_seq(3, 100, 2, 0, 0, 0, 1100000, 1'b0);
    chk("R9 lock on last allowed read", 32'(got_err), 32'd0);
    chk("R9 post-lock write done", 32'(c2_writes), 32'd2);
    prep();
    lock_after = WP;
    run_seq(3, 100, 2, 0, 0, 0, 1100000, 1'b0);
    chk("R9 lock one read late", 32'(got_err), 32'd1);
    chk("R9 lock late no post write", 32'(c2_writes), 32'd1);
    quiet_after("R9 quiet after lock timeout");
  endtask

  task automatic t_ack();
    prep();
    ack_ok = 1'b0;
    run_seq(2, 80, 4, 0, 0, 9, 1600000, 1'b0);
    chk("R8 missing acknowledge errors", 32'(got_err), 32'd1);
    prep();
    ack_ok = 1'b0;
    run_seq(2, 80, 0, 0, 0, 0, 1600000, 1'b0);
    chk("R8 no dividers no wait", 32'(got_err), 32'd0);
    chk("R7 no enables", c2b, exp_c2b(1600000, 0, 0, 0, 0));
  endtask

  task automatic t_retry_ok();
    prep();
    go_busy_reads = 0; lock_after = 0; lock_from_try = 3;
    run_seq(5, 200, 3, 0, 0, 0, 1200000, 1'b1);
    chk("R10 retry locks on third try", 32'(got_err), 32'd0);
    chk("R10 three apply writes", 32'(go_writes), 32'd3);
    chk("R10 settle respected", 32'(min_gap >= SC), 32'd1);
    prep();
    go_busy_reads = 0; lock_after = 0; lock_bits = 32'h93;
    run_seq(5, 200, 3, 0, 0, 0, 1200000, 1'b1);
    chk("R10 unmasked bits ignored", 32'(got_err), 32'd0);
    chk("R10 first try accepted", 32'(go_writes), 32'd1);
  endtask

  task automatic t_retry_fail();
    prep();
    go_busy_reads = 0; lock_after = 0; lock_bits = 32'h23;
    run_seq(5, 200, 3, 0, 0, 0, 1200000, 1'b1);
    chk("R11 jitter never accepted", 32'(got_err), 32'd1);
    chk("R11 attempt limit", 32'(go_writes), 32'(MT));
    quiet_after("R11 quiet after give-up");
    prep();
    go_busy_reads = 1000; lock_after = 0;
    run_seq(5, 200, 3, 0, 0, 0, 1200000, 1'b1);
    chk("R10 apply bit held fails", 32'(got_err), 32'd1);
    chk("R11 attempt limit held bit", 32'(go_writes), 32'(MT));
  endtask

  task automatic t_busy_start();
    int d0;
    prep();
    d0 = done_cnt;
    @(negedge clk);
    div_n = 8'd6; div_m = 12'd77; post_div0 = 5'd2; post_div1 = 5'd0;
    post_div2 = 5'd0; post_div3 = 5'd0; fint_hz = 32'd950000; retry_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    div_n = 8'd9; div_m = 12'd11; post_div1 = 5'd4; retry_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    quiet_after("R12 no second run");
    chk("R12 first inputs kept", c1, exp_c1(6, 77, 2, 0));
    chk("R12 one apply write", 32'(go_writes), 32'd1);
    chk("R12 one done pulse", 32'(done_cnt - d0), 32'd1);
  endtask

  initial begin
    prep();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_all_div();
    t_partial();
    t_fsel_edges();
    t_go_stuck();
    t_lock_edge();
    t_ack();
    t_retry_ok();
    t_retry_fail();
    t_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule